// File: doc/BRIEF.md
# Loop Code Detector with Automatic Remote Loopback

This block monitors the single-rail receive bit stream of one line channel for two repeating in-band control patterns. The first is a loop-up request, a repeating five-bit code. The second is a loop-down request, a repeating three-bit code. A pattern only counts once it has been present without a break for longer than a programmable hold time, given in bit-clock counts. When that happens, the block latches a detect status bit. If the interrupt enable is high, it also raises an interrupt.

A two-bit mode input selects the behaviour. Detection can be off, or the block can search for one code under manual control. In manual modes it only reports and never changes the line. In the automatic mode it runs a two-phase sequence. It searches for loop-up first. When loop-up is confirmed, it raises a remote-loopback enable and changes its search to loop-down. It keeps the loopback and the status across the gap between the two codes. A confirmed loop-down releases the loopback. Leaving automatic mode also releases it.

Top module: `loop_code_detector`

## Requirements
- R1: The mode input is decoded as follows: 2'b00 disables detection, 2'b01 searches for loop-up only, 2'b10 searches for loop-down only, and 2'b11 is automatic mode. While the mode is 2'b00, no code stream can set the status.
- R2: Only bits with bit_vld high enter the detector. A bit with bit_vld low neither advances nor breaks a run. Loop-up is present when the last 5 valid bits (received order) are a rotation of 0,0,0,0,1, meaning exactly one 1 among them. Loop-down is present when the last 3 valid bits hold exactly one 1. A code cannot be present before that many valid bits have arrived since reset.
- R3: Each valid bit that shows the searched code adds one to a run. A valid bit that does not show it clears the run, and so does a change of which code is searched. The status sets on the clock edge of the (HOLD_BITS+1)-th consecutive present bit.
- R4: irq is high whenever det_status is high and irq_en is high.
- R5: In modes 2'b00, 2'b01 and 2'b10, rloop_en is low from the cycle after that mode is applied.
- R6: On the first cycle in mode 2'b11 after any other mode, the status clears and the search is for loop-up.
- R7: In automatic mode, a confirmed loop-up sets the status and rloop_en on the same edge and changes the search to loop-down.
- R8: The status stays set after the code stops. It clears only on status_clr or on entry to automatic mode. A detection in the same cycle as either of these leaves it set.
- R9: In automatic mode, a confirmed loop-down clears rloop_en, keeps the status, and returns the search to loop-up.
- R10: After reset, det_status, irq and rloop_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Qualifies rx_bit for this cycle |
| rx_bit | input | 1 | Single-rail receive data bit |
| mode | input | 2 | Detection mode select |
| irq_en | input | 1 | Interrupt enable |
| status_clr | input | 1 | Host strobe that clears the detect status |
| det_status | output | 1 | Sticky detect status |
| irq | output | 1 | Interrupt request |
| rloop_en | output | 1 | Remote loopback enable |

## Verification
Two functions can act on the status in the same cycle. A detection can set it while the host clear strobe, or the clear on entry to automatic mode, tries to clear it. A directed case builds a run of exactly HOLD_BITS present bits and then applies status_clr on the bit that completes the detection. The random phase drops clear strobes onto long code streams so that both coincidences recur. Each case is judged against a bench model in which the set wins, checked on every cycle at the status and interrupt pins.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  localparam int WIN_W   = 5;
  localparam int FILL_W  = 3;
  localparam int UP_PER  = 5;
  localparam int DN_PER  = 3;
  localparam logic [WIN_W-1:0] UP_CODE = 5'b00001;
  localparam logic [WIN_W-1:0] DN_CODE = 5'b00001;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DN   = 2'b10,
    MODE_AUTO = 2'b11
  } lcd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_LOOP = 2'd2
  } lcd_state_e;

  // Low-order mask for a code of the given period.
  function automatic logic [WIN_W-1:0] per_mask(input int per);
    per_mask = WIN_W'((1 << per) - 1);
  endfunction

  // True when the low per bits of win equal some cyclic rotation of code.
  function automatic logic rot_match(input logic [WIN_W-1:0] win,
                                     input logic [WIN_W-1:0] code,
                                     input int per);
    logic [WIN_W-1:0] msk;
    logic [WIN_W-1:0] rot;
    logic             hit;
    msk = per_mask(per);
    hit = 1'b0;
    for (int r = 0; r < WIN_W; r++) begin
      if (r < per) begin
        rot = ((code << r) | (code >> (per - r))) & msk;
        if ((win & msk) == rot) hit = 1'b1;
      end
    end
    rot_match = hit;
  endfunction

  // Saturating increment used for the run counter.
  function automatic int unsigned sat_inc(input int unsigned v,
                                          input int unsigned lim);
    sat_inc = (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/lcd_history.sv
module lcd_history
  import lcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              rx_bit,
  output logic [WIN_W-1:0]  win,
  output logic [FILL_W-1:0] fill
);

  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WIN_W - 1);

  logic [WIN_W-2:0]  hist_q;
  logic [FILL_W-1:0] fill_q;

  // Window including the current bit; win[0] is the newest.
  assign win  = {hist_q, rx_bit};
  assign fill = fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_vld) begin
      hist_q <= win[WIN_W-2:0];
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_code_timer.sv
module lcd_code_timer
  import lcd_pkg::*;
#(
  parameter int                PER       = 5,
  parameter logic [WIN_W-1:0]  CODE      = 5'b00001,
  parameter int unsigned       HOLD_BITS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_vld,
  input  logic [WIN_W-1:0]  win,
  input  logic [FILL_W-1:0] fill,
  output logic              present,
  output logic              hit
);

  localparam int unsigned SAT   = HOLD_BITS + 1;
  localparam int          CNT_W = $clog2(SAT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             avail;

  assign avail   = (fill >= FILL_W'(PER - 1));
  assign present = avail && rot_match(win, CODE, PER);
  assign hit     = en && bit_vld && present && (cnt_q == CNT_W'(HOLD_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (bit_vld) begin
      if (present) cnt_q <= CNT_W'(sat_inc(int'(cnt_q), SAT));
      else         cnt_q <= '0;
    end
  end

endmodule

// File: rtl/lcd_ctrl.sv
module lcd_ctrl
  import lcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       status_clr,
  input  logic       hit_up,
  input  logic       hit_dn,
  output logic       en_up,
  output logic       en_dn,
  output lcd_state_e state,
  output logic       status,
  output logic       rloop
);

  lcd_state_e st_q, st_d;
  logic       status_q, rloop_q, rloop_d;
  logic       is_auto, entry, any_hit;

  assign is_auto = (lcd_mode_e'(mode) == MODE_AUTO);
  assign entry   = is_auto && (st_q == ST_IDLE);
  assign any_hit = hit_up || hit_dn;

  assign en_up = (lcd_mode_e'(mode) == MODE_UP) || (is_auto && st_q != ST_LOOP);
  assign en_dn = (lcd_mode_e'(mode) == MODE_DN) || (is_auto && st_q == ST_LOOP);

  always_comb begin
    st_d    = st_q;
    rloop_d = rloop_q;
    if (!is_auto) begin
      st_d    = ST_IDLE;
      rloop_d = 1'b0;
    end else if (hit_up) begin
      st_d    = ST_LOOP;
      rloop_d = 1'b1;
    end else if (hit_dn) begin
      st_d    = ST_ARM;
      rloop_d = 1'b0;
    end else if (st_q == ST_IDLE) begin
      st_d    = ST_ARM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rloop_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rloop_q <= rloop_d;
      if (any_hit)                  status_q <= 1'b1;
      else if (status_clr || entry) status_q <= 1'b0;
    end
  end

  assign state  = st_q;
  assign status = status_q;
  assign rloop  = rloop_q;

endmodule

// File: rtl/loop_code_detector.sv
module loop_code_detector
  import lcd_pkg::*;
#(
  parameter int unsigned HOLD_BITS = 7_720_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       rx_bit,
  input  logic [1:0] mode,
  input  logic       irq_en,
  input  logic       status_clr,
  output logic       det_status,
  output logic       irq,
  output logic       rloop_en
);

  localparam int NCODE = 2;

  logic [WIN_W-1:0]  win;
  logic [FILL_W-1:0] fill;
  logic [NCODE-1:0]  code_en;
  logic [NCODE-1:0]  code_hit;
  logic [NCODE-1:0]  code_present;
  logic              hit_up, hit_dn;
  lcd_state_e        ctrl_state;

  lcd_history i_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .rx_bit  (rx_bit),
    .win     (win),
    .fill    (fill)
  );

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    localparam int               PER  = (g == 0) ? UP_PER  : DN_PER;
    localparam logic [WIN_W-1:0] CODE = (g == 0) ? UP_CODE : DN_CODE;
    lcd_code_timer #(
      .PER       (PER),
      .CODE      (CODE),
      .HOLD_BITS (HOLD_BITS)
    ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (code_en[g]),
      .bit_vld (bit_vld),
      .win     (win),
      .fill    (fill),
      .present (code_present[g]),
      .hit     (code_hit[g])
    );
  end

  assign hit_up = code_hit[0];
  assign hit_dn = code_hit[1];

  lcd_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .status_clr (status_clr),
    .hit_up     (hit_up),
    .hit_dn     (hit_dn),
    .en_up      (code_en[0]),
    .en_dn      (code_en[1]),
    .state      (ctrl_state),
    .status     (det_status),
    .rloop      (rloop_en)
  );

  assign irq = det_status & irq_en;

endmodule

// File: rtl/lcd_checker.sv
module lcd_checker
  import lcd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       irq_en,
  input logic       status_clr,
  input logic       det_status,
  input logic       irq,
  input logic       rloop_en,
  input lcd_state_e state,
  input logic       hit_up,
  input logic       hit_dn
);

  assert_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> (!hit_up && !hit_dn));

  assert_one_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_up && hit_dn));

  assert_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(det_status) && irq_en) |-> irq);

  assert_manual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_AUTO) |=> !rloop_en);

  assert_entry_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_AUTO && state == ST_IDLE && !hit_up) |=> !det_status);

  assert_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_AUTO && hit_up) |=> (rloop_en && det_status && state == ST_LOOP));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (det_status && !status_clr && !(mode == MODE_AUTO && state == ST_IDLE)) |=> det_status);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_AUTO && state == ST_LOOP && hit_dn) |=>
      (!rloop_en && det_status && state == ST_ARM));

endmodule

bind loop_code_detector lcd_checker i_lcd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .irq_en     (irq_en),
  .status_clr (status_clr),
  .det_status (det_status),
  .irq        (irq),
  .rloop_en   (rloop_en),
  .state      (ctrl_state),
  .hit_up     (hit_up),
  .hit_dn     (hit_dn)
);

// File: tb/test_loop_code_detector.sv
`timescale 1ns/1ps
module test_loop_code_detector;

  localparam int HOLD = 20;

  logic       clk = 1'b0;
  logic       rst_n, bit_vld, rx_bit, irq_en, status_clr;
  logic [1:0] mode;
  wire        det_status, irq, rloop_en;

  always #2 clk = ~clk;

  loop_code_detector #(.HOLD_BITS(HOLD)) i_loop_code_detector (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .mode(mode), .irq_en(irq_en), .status_clr(status_clr),
    .det_status(det_status), .irq(irq), .rloop_en(rloop_en)
  );

  int vectors = 0;
  int fails   = 0;
  int ph      = 0;

  // Bench model state
  logic [4:0] m_hist;
  int         m_fill;
  int         m_run [2];
  int         m_state;   // 0 idle, 1 searching up, 2 looped
  logic       m_status, m_rloop;

  function automatic bit code_seen(int k, logic [4:0] w, int nbits);
    int per = (k == 0) ? 5 : 3;
    if (nbits < per) return 1'b0;
    return $countones(w & 5'((1 << per) - 1)) == 1;
  endfunction

  task automatic model_reset();
    m_hist = '0; m_fill = 0; m_run[0] = 0; m_run[1] = 0;
    m_state = 0; m_status = 1'b0; m_rloop = 1'b0;
  endtask

  task automatic model_step();
    logic [4:0] w;
    int  nb;
    bit  en [2];
    bit  hit [2];
    w  = {m_hist[3:0], rx_bit};
    nb = m_fill + 1;
    en[0] = (mode == 2'b01) || (mode == 2'b11 && m_state != 2);
    en[1] = (mode == 2'b10) || (mode == 2'b11 && m_state == 2);
    for (int k = 0; k < 2; k++) begin
      hit[k] = 1'b0;
      if (!en[k]) m_run[k] = 0;
      else if (bit_vld) begin
        if (code_seen(k, w, nb)) begin
          hit[k] = (m_run[k] == HOLD);
          if (m_run[k] <= HOLD) m_run[k]++;
        end else m_run[k] = 0;
      end
    end
    if (hit[0] || hit[1]) m_status = 1'b1;
    else if (status_clr || (mode == 2'b11 && m_state == 0)) m_status = 1'b0;
    if (mode != 2'b11) begin m_state = 0; m_rloop = 1'b0; end
    else if (hit[0]) begin m_state = 2; m_rloop = 1'b1; end
    else if (hit[1]) begin m_state = 1; m_rloop = 1'b0; end
    else if (m_state == 0) m_state = 1;
    if (bit_vld) begin
      m_hist = w;
      m_fill = (nb > 5) ? 5 : nb;
    end
  endtask

  task automatic check(string tag, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One clock: model advances with applied inputs, outputs compared after the edge.
  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check({tag, "/R3"}, det_status, m_status, "det_status");
    check({tag, "/R7"}, rloop_en, m_rloop, "rloop_en");
    check({tag, "/R4"}, irq, m_status & irq_en, "irq");
  endtask

  // kind: 0 loop-up stream, 1 loop-down stream, 2 random
  task automatic feed(int n, int kind, int vld_pct, int glitch_pct, int clr_pct, string tag);
    for (int i = 0; i < n; i++) begin
      bit_vld    = (($urandom % 100) < vld_pct);
      status_clr = (($urandom % 100) < clr_pct);
      case (kind)
        0:       rx_bit = (ph % 5 == 4);
        1:       rx_bit = (ph % 3 == 2);
        default: rx_bit = $urandom % 2;
      endcase
      if (($urandom % 1000) < glitch_pct * 10) rx_bit = ~rx_bit;
      if (bit_vld) ph++;
      step(tag);
    end
    status_clr = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de5));
    rst_n = 1'b0; bit_vld = 1'b0; rx_bit = 1'b0; mode = 2'b00;
    irq_en = 1'b0; status_clr = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R10", det_status, 1'b0, "det_status after reset");
    check("R10", irq, 1'b0, "irq after reset");
    check("R10", rloop_en, 1'b0, "rloop_en after reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: mode off ignores a long loop-up stream
    irq_en = 1'b1;
    ph = 0; feed(3 * HOLD, 0, 100, 0, 0, "R1_off");
    check("R1", det_status, 1'b0, "status in mode off");

    // R3 boundary: window primed in mode off, then exactly HOLD present bits
    mode = 2'b01;
    feed(HOLD, 0, 100, 0, 0, "R3_edge");
    check("R3", det_status, 1'b0, "status after HOLD present bits");
    feed(1, 0, 100, 0, 0, "R3_edge");
    check("R3", det_status, 1'b1, "status after HOLD+1 present bits");
    check("R4", irq, 1'b1, "irq with enable");
    irq_en = 1'b0;
    feed(1, 2, 0, 0, 0, "R4_mask");
    check("R4", irq, 1'b0, "irq masked");
    check("R5", rloop_en, 1'b0, "rloop in manual up");

    // R8: sticky, then clear, then clear colliding with a detection
    feed(10, 2, 100, 0, 0, "R8_sticky");
    check("R8", det_status, 1'b1, "status held after code stops");
    mode = 2'b00; ph = 0;
    feed(5, 0, 100, 0, 0, "R8_prime");
    status_clr = 1'b1; bit_vld = 1'b0; step("R8_clr"); status_clr = 1'b0;
    check("R8", det_status, 1'b0, "status after clear strobe");
    mode = 2'b01;
    feed(HOLD, 0, 100, 0, 0, "R8_race");
    bit_vld = 1'b1; rx_bit = (ph % 5 == 4); ph++; status_clr = 1'b1;
    step("R8_race"); status_clr = 1'b0;
    check("R8", det_status, 1'b1, "detection beats clear");

    // R2: loop-up stream in loop-down mode does not match; gaps of bit_vld low ignored
    mode = 2'b00; bit_vld = 0; status_clr = 1'b1; step("R2_clr"); status_clr = 1'b0;
    mode = 2'b10;
    feed(4 * HOLD, 0, 100, 0, 0, "R2_cross");
    check("R2", det_status, 1'b0, "loop-up not taken as loop-down");
    ph = 0;
    feed(3 * HOLD, 1, 60, 0, 0, "R2_gaps");
    check("R2", det_status, 1'b1, "loop-down with valid gaps detected");
    check("R5", rloop_en, 1'b0, "rloop in manual down");

    // Automatic sequence
    mode = 2'b11; bit_vld = 1'b0; step("R6_entry");
    check("R6", det_status, 1'b0, "status cleared on auto entry");
    ph = 0;
    feed(HOLD + 10, 0, 100, 0, 0, "R7_up");
    check("R7", rloop_en, 1'b1, "loopback raised");
    check("R7", det_status, 1'b1, "status on loop-up");
    feed(40, 2, 100, 0, 0, "R8_gap");
    check("R8", rloop_en, 1'b1, "loopback held in gap");
    check("R8", det_status, 1'b1, "status held in gap");
    ph = 0;
    feed(HOLD + 10, 1, 100, 0, 0, "R9_down");
    check("R9", rloop_en, 1'b0, "loopback released by loop-down");
    check("R9", det_status, 1'b1, "status kept after loop-down");
    ph = 0;
    feed(HOLD + 10, 0, 100, 0, 0, "R9_rearm");
    check("R9", rloop_en, 1'b1, "loop-up searched again");
    mode = 2'b01; bit_vld = 1'b0; step("R5_leave");
    check("R5", rloop_en, 1'b0, "leaving auto drops loopback");

    // Random phase
    for (int s = 0; s < 1800; s++) begin
      int r = $urandom % 10;
      mode   = (r < 5) ? 2'b11 : 2'($urandom % 4);
      irq_en = $urandom % 2;
      feed(1 + $urandom % (3 * HOLD), $urandom % 3, 70 + $urandom % 31,
           ($urandom % 4 == 0) ? 2 : 0, 3, "rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule